// File: doc/BRIEF.md
# Hotplug Event Register Bank

This block keeps the record of processor and expansion-slot hotplug events for the power-management logic. Whenever a processor is inserted or removed, it sets one shared event status bit and updates that processor's bit in a presence bitmap. Whenever a slot is inserted or removed, it sets a second status bit and records the slot in either an "up" mask or a "down" mask. A single level output tells the interrupt logic that an enabled event is pending.

Software reaches the block through a byte-wide register port with two windows. The event window holds a 16-bit status register and a 16-bit enable register, each split into two byte lanes. Status bits are cleared by writing ones to them. The processor window exposes the presence bitmap one byte at a time and is read-only. At reset the bitmap is loaded with the processors that exist at power-up. Event inputs are single-cycle strobes with no back-pressure: the block accepts an event on every cycle its strobe is high. Register reads are combinational on the current address, and every write or event takes effect at the next rising clock edge.

Top module: `hp_event_bank`

## Requirements
- R1: With `acc_win`=0, offsets 0 and 1 read the low and high bytes of status, and offsets 2 and 3 read the low and high bytes of enable. After reset, all four bytes read 0, both slot masks are 0, and `gpe_event` is low.
- R2: A write with `acc_win`=0 to offset 0 or 1 clears those status bits in the addressed byte where the written byte has a one. All other status bits keep their value.
- R3: A write with `acc_win`=0 to offset 2 or 3 replaces only the addressed byte of enable. The other byte is unchanged.
- R4: A processor insert event for index n sets status bit 2 and sets bit n%8 of bitmap byte n/8. The bitmap byte is read with `acc_win`=1 at offset n/8.
- R5: A processor remove event for index n sets status bit 2 and clears bit n%8 of bitmap byte n/8. The other bitmap bits are unchanged.
- R6: A slot insert event for slot s sets status bit 1, makes `slot_up` equal to 1<<s, and makes `slot_down` zero.
- R7: A slot remove event for slot s sets status bit 1, makes `slot_down` equal to 1<<s, and makes `slot_up` zero.
- R8: After reset, bitmap bit i is 1 exactly when i < NUM_PRESENT. Each whole byte below the count reads 0xFF, and a final partial byte reads (1<<(NUM_PRESENT%8))-1.
- R9: `gpe_event` is high exactly when status AND enable has bit 1 or bit 2 set.
- R10: With `acc_win`=0, offsets 4 and above read 0xFF, and writes to them change no register.
- R11: If an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R12: Writes with `acc_win`=1 leave the presence bitmap unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_win | input | 1 | Window select: 0 = event registers, 1 = processor bitmap |
| acc_addr | input | 5 | Byte offset within the selected window |
| acc_wr | input | 1 | Write strobe for the current offset |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte for the current window and offset |
| cpu_evt_valid | input | 1 | Processor hotplug event strobe |
| cpu_evt_idx | input | 8 | Processor index |
| cpu_evt_insert | input | 1 | 1 = insert, 0 = remove |
| slot_evt_valid | input | 1 | Slot hotplug event strobe |
| slot_evt_idx | input | 5 | Slot number |
| slot_evt_insert | input | 1 | 1 = insert, 0 = remove |
| slot_up | output | 32 | Mask of the slot from the latest insert event |
| slot_down | output | 32 | Mask of the slot from the latest remove event |
| gpe_event | output | 1 | Level: an enabled processor or slot event is pending |

## Verification
Each write or event strobe is seen at one rising edge and changes the registers at that same edge. So `slot_up`, `slot_down`, `gpe_event` and the read byte for any offset show the result from that edge onward, with no extra pipeline delay. `acc_rdata` follows the address within the cycle. The bench drives inputs on the falling edge, updates its reference model on the rising edge, and compares every output a quarter period after each rising edge. It also performs directed reads that are sampled shortly after the address is set up.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef enum logic {WIN_GPE = 1'b0, WIN_CPU = 1'b1} win_e;

  localparam int STS_W        = 16;
  localparam int GPE_BYTES    = 4;
  localparam int STS_SLOT_BIT = 1;
  localparam int STS_CPU_BIT  = 2;

  // Presence image for one bitmap byte: bit i set when (b*8+i) < n
  function automatic logic [7:0] present_byte(input int b, input int n);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = ((b * 8 + i) < n);
    return v;
  endfunction
endpackage

// File: rtl/hp_gpe_regs.sv
module hp_gpe_regs
  import hp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             cpu_set,
  input  logic             slot_set,
  output logic [STS_W-1:0] sts_q,
  output logic [STS_W-1:0] en_q,
  output logic [7:0]       rd_byte
);
  localparam int LANES = STS_W / 8;

  logic [STS_W-1:0] set_mask;
  always_comb begin
    set_mask = '0;
    set_mask[STS_CPU_BIT]  = cpu_set;
    set_mask[STS_SLOT_BIT] = slot_set;
  end

  // addr[1] picks status (0) or enable (1); addr[0] picks the lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic hit;
    assign hit = wr_en && (int'(addr[0]) == l);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sts_q[l*8 +: 8] <= '0;
        en_q[l*8 +: 8]  <= '0;
      end else begin
        // clear first, then OR in events so a set wins
        sts_q[l*8 +: 8] <= ((hit && !addr[1]) ? (sts_q[l*8 +: 8] & ~wdata)
                                              : sts_q[l*8 +: 8])
                           | set_mask[l*8 +: 8];
        if (hit && addr[1]) en_q[l*8 +: 8] <= wdata;
      end
    end
  end

  always_comb begin
    unique case (addr)
      2'd0:    rd_byte = sts_q[7:0];
      2'd1:    rd_byte = sts_q[15:8];
      2'd2:    rd_byte = en_q[7:0];
      default: rd_byte = en_q[15:8];
    endcase
  end
endmodule

// File: rtl/hp_cpu_map.sv
module hp_cpu_map
  import hp_pkg::*;
#(
  parameter int MAP_BYTES   = 32,
  parameter int NUM_PRESENT = 1,
  localparam int IDX_W  = $clog2(MAP_BYTES * 8),
  localparam int ADDR_W = $clog2(MAP_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   evt_valid,
  input  logic [IDX_W-1:0]       evt_idx,
  input  logic                   evt_insert,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_byte,
  output logic [MAP_BYTES*8-1:0] map_q
);
  for (genvar b = 0; b < MAP_BYTES; b++) begin : g_byte
    logic hit;
    assign hit = evt_valid && (int'(evt_idx[IDX_W-1:3]) == b);

    always_ff @(posedge clk) begin
      if (!rst_n)
        map_q[b*8 +: 8] <= present_byte(b, NUM_PRESENT);
      else if (hit)
        map_q[b*8 + int'(evt_idx[2:0])] <= evt_insert;
    end
  end

  assign rd_byte = map_q[int'(rd_addr)*8 +: 8];
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs #(
  parameter int SLOTS = 32,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [IDX_W-1:0] evt_idx,
  input  logic             evt_insert,
  output logic [SLOTS-1:0] up_q,
  output logic [SLOTS-1:0] down_q
);
  logic [SLOTS-1:0] onehot;
  assign onehot = {{(SLOTS-1){1'b0}}, 1'b1} << evt_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q   <= '0;
      down_q <= '0;
    end else if (evt_valid) begin
      // each event forgets the previous one
      up_q   <= evt_insert ? onehot : '0;
      down_q <= evt_insert ? '0 : onehot;
    end
  end
endmodule

// File: rtl/hp_event_bank.sv
module hp_event_bank
  import hp_pkg::*;
#(
  parameter int MAP_BYTES   = 32,
  parameter int SLOTS       = 32,
  parameter int NUM_PRESENT = 11,
  localparam int ADDR_W     = $clog2(MAP_BYTES),
  localparam int CPU_IDX_W  = $clog2(MAP_BYTES * 8),
  localparam int SLOT_IDX_W = $clog2(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_win,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic                  acc_wr,
  input  logic [7:0]            acc_wdata,
  output logic [7:0]            acc_rdata,
  input  logic                  cpu_evt_valid,
  input  logic [CPU_IDX_W-1:0]  cpu_evt_idx,
  input  logic                  cpu_evt_insert,
  input  logic                  slot_evt_valid,
  input  logic [SLOT_IDX_W-1:0] slot_evt_idx,
  input  logic                  slot_evt_insert,
  output logic [SLOTS-1:0]      slot_up,
  output logic [SLOTS-1:0]      slot_down,
  output logic                  gpe_event
);
  win_e                   win;
  logic                   gpe_mapped;
  logic [STS_W-1:0]       sts_q, en_q;
  logic [7:0]             gpe_byte, map_byte;
  logic [MAP_BYTES*8-1:0] map_q;
  logic [STS_W-1:0]       evt_mask;

  assign win        = win_e'(acc_win);
  assign gpe_mapped = (int'(acc_addr) < GPE_BYTES);

  hp_gpe_regs u_gpe (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc_wr && win == WIN_GPE && gpe_mapped),
    .addr     (acc_addr[1:0]),
    .wdata    (acc_wdata),
    .cpu_set  (cpu_evt_valid),
    .slot_set (slot_evt_valid),
    .sts_q    (sts_q),
    .en_q     (en_q),
    .rd_byte  (gpe_byte)
  );

  hp_cpu_map #(.MAP_BYTES(MAP_BYTES), .NUM_PRESENT(NUM_PRESENT)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (cpu_evt_valid),
    .evt_idx    (cpu_evt_idx),
    .evt_insert (cpu_evt_insert),
    .rd_addr    (acc_addr),
    .rd_byte    (map_byte),
    .map_q      (map_q)
  );

  hp_slot_regs #(.SLOTS(SLOTS)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (slot_evt_valid),
    .evt_idx    (slot_evt_idx),
    .evt_insert (slot_evt_insert),
    .up_q       (slot_up),
    .down_q     (slot_down)
  );

  always_comb begin
    if (win == WIN_CPU)  acc_rdata = map_byte;
    else if (gpe_mapped) acc_rdata = gpe_byte;
    else                 acc_rdata = 8'hFF;
  end

  always_comb begin
    evt_mask = '0;
    evt_mask[STS_CPU_BIT]  = 1'b1;
    evt_mask[STS_SLOT_BIT] = 1'b1;
  end
  assign gpe_event = |(sts_q & en_q & evt_mask);
endmodule

// File: rtl/hp_event_bank_chk.sv
module hp_event_bank_chk #(
  parameter int MAP_BYTES = 32,
  parameter int SLOTS     = 32,
  localparam int ADDR_W     = $clog2(MAP_BYTES),
  localparam int CPU_IDX_W  = $clog2(MAP_BYTES * 8),
  localparam int SLOT_IDX_W = $clog2(SLOTS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_win,
  input logic [ADDR_W-1:0]     acc_addr,
  input logic                  acc_wr,
  input logic [7:0]            acc_wdata,
  input logic                  cpu_evt_valid,
  input logic [CPU_IDX_W-1:0]  cpu_evt_idx,
  input logic                  cpu_evt_insert,
  input logic                  slot_evt_valid,
  input logic [SLOT_IDX_W-1:0] slot_evt_idx,
  input logic                  slot_evt_insert,
  input logic [SLOTS-1:0]      slot_up,
  input logic [SLOTS-1:0]      slot_down,
  input logic [15:0]           sts_q,
  input logic [15:0]           en_q,
  input logic [MAP_BYTES*8-1:0] map_q
);
  logic en_wr;
  assign en_wr = acc_wr && !acc_win && (acc_addr == 2 || acc_addr == 3);

  AST_STS_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !acc_win && acc_addr == 0 && !cpu_evt_valid && !slot_evt_valid)
      |=> (sts_q[7:0] & $past(acc_wdata)) == 8'h00); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q)); // R3
  AST_CPU_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_evt_valid |=> sts_q[2]); // R11
  AST_CPU_MAP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_evt_valid |=> map_q[$past(cpu_evt_idx)] == $past(cpu_evt_insert)); // R4
  AST_SLOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_evt_valid && slot_evt_insert)
      |=> sts_q[1] && $onehot0(slot_up) && slot_up[$past(slot_evt_idx)]
          && slot_down == '0); // R6
  AST_SLOT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_evt_valid && !slot_evt_insert)
      |=> sts_q[1] && $onehot0(slot_down) && slot_down[$past(slot_evt_idx)]
          && slot_up == '0); // R7
  AST_MAP_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_win && !cpu_evt_valid) |=> $stable(map_q)); // R12
endmodule

bind hp_event_bank hp_event_bank_chk #(.MAP_BYTES(MAP_BYTES), .SLOTS(SLOTS)) chk_i (.*);

// File: tb/hp_event_bank_tb_top.sv
module hp_event_bank_tb_top;
  localparam int NP = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_win = 1'b0;
  logic [4:0]  acc_addr = '0;
  logic        acc_wr = 1'b0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  acc_rdata;
  logic        cpu_evt_valid = 1'b0;
  logic [7:0]  cpu_evt_idx = '0;
  logic        cpu_evt_insert = 1'b0;
  logic        slot_evt_valid = 1'b0;
  logic [4:0]  slot_evt_idx = '0;
  logic        slot_evt_insert = 1'b0;
  logic [31:0] slot_up, slot_down;
  logic        gpe_event;

  int checks = 0;
  int failures = 0;

  hp_event_bank #(.MAP_BYTES(32), .SLOTS(32), .NUM_PRESENT(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_win(acc_win), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .cpu_evt_valid(cpu_evt_valid), .cpu_evt_idx(cpu_evt_idx),
    .cpu_evt_insert(cpu_evt_insert), .slot_evt_valid(slot_evt_valid),
    .slot_evt_idx(slot_evt_idx), .slot_evt_insert(slot_evt_insert),
    .slot_up(slot_up), .slot_down(slot_down), .gpe_event(gpe_event));

  always #10 clk = ~clk;

  // behavioural reference model
  logic [15:0]  m_sts, m_en;
  logic [255:0] m_map;
  logic [31:0]  m_up, m_dn;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_up = 0; m_dn = 0;
      for (int i = 0; i < 256; i++) m_map[i] = (i < NP);
    end else begin
      if (acc_wr && !acc_win) begin
        case (acc_addr)
          5'd0: m_sts[7:0]  = m_sts[7:0]  & ~acc_wdata;
          5'd1: m_sts[15:8] = m_sts[15:8] & ~acc_wdata;
          5'd2: m_en[7:0]   = acc_wdata;
          5'd3: m_en[15:8]  = acc_wdata;
          default: ;
        endcase
      end
      if (cpu_evt_valid) begin
        m_sts[2] = 1'b1;
        m_map[cpu_evt_idx] = cpu_evt_insert;
      end
      if (slot_evt_valid) begin
        m_sts[1] = 1'b1;
        m_up = 0; m_dn = 0;
        if (slot_evt_insert) m_up[slot_evt_idx] = 1'b1;
        else                 m_dn[slot_evt_idx] = 1'b1;
      end
    end
  end

  function automatic logic [7:0] m_read(input logic w, input logic [4:0] a);
    if (w) return m_map[a*8 +: 8];
    case (a)
      5'd0: return m_sts[7:0];
      5'd1: return m_sts[15:8];
      5'd2: return m_en[7:0];
      5'd3: return m_en[15:8];
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk("R9 cycle gpe_event", {31'd0, gpe_event}, {31'd0, |(m_sts & m_en & 16'h0006)});
      chk("R6/R7 cycle slot_up", slot_up, m_up);
      chk("R6/R7 cycle slot_down", slot_down, m_dn);
      chk("R1 cycle rdata", {24'd0, acc_rdata}, {24'd0, m_read(acc_win, acc_addr)});
    end
  end

  task automatic wr(input logic w, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_win = w; acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic w, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    acc_win = w; acc_addr = a;
    #2;
    chk(tag, {24'd0, acc_rdata}, {24'd0, exp});
  endtask

  task automatic cpu_ev(input logic [7:0] idx, input logic ins);
    @(negedge clk);
    cpu_evt_valid = 1'b1; cpu_evt_idx = idx; cpu_evt_insert = ins;
    @(negedge clk);
    cpu_evt_valid = 1'b0;
  endtask

  task automatic slot_ev(input logic [4:0] idx, input logic ins);
    @(negedge clk);
    slot_evt_valid = 1'b1; slot_evt_idx = idx; slot_evt_insert = ins;
    @(negedge clk);
    slot_evt_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd_chk("R1 reset sts lo", 0, 0, 8'h00);
    rd_chk("R1 reset sts hi", 0, 1, 8'h00);
    rd_chk("R1 reset en lo", 0, 2, 8'h00);
    rd_chk("R1 reset en hi", 0, 3, 8'h00);
    chk("R1 reset slot masks", slot_up | slot_down, 32'd0);
    chk("R1 reset gpe_event", {31'd0, gpe_event}, 32'd0);
    rd_chk("R8 full byte", 1, 0, 8'hFF);
    rd_chk("R8 partial byte", 1, 1, 8'h07);
    rd_chk("R8 empty byte", 1, 2, 8'h00);
    rd_chk("R8 last byte", 1, 31, 8'h00);
    // enable lanes
    wr(0, 2, 8'h06);
    wr(0, 3, 8'hAB);
    rd_chk("R3 en lo", 0, 2, 8'h06);
    rd_chk("R3 en hi", 0, 3, 8'hAB);
    wr(0, 3, 8'h5C);
    rd_chk("R3 en lo kept", 0, 2, 8'h06);
    rd_chk("R3 en hi new", 0, 3, 8'h5C);
    // processor insert
    cpu_ev(8'd20, 1'b1);
    rd_chk("R4 sts bit2", 0, 0, 8'h04);
    rd_chk("R4 map byte2", 1, 2, 8'h10);
    chk("R9 event high", {31'd0, gpe_event}, 32'd1);
    // status clearing
    wr(0, 1, 8'hFF);
    rd_chk("R2 other lane", 0, 0, 8'h04);
    wr(0, 0, 8'h02);
    rd_chk("R2 zero bit kept", 0, 0, 8'h04);
    wr(0, 0, 8'h04);
    rd_chk("R2 cleared", 0, 0, 8'h00);
    chk("R9 event low", {31'd0, gpe_event}, 32'd0);
    // processor remove
    cpu_ev(8'd1, 1'b0);
    rd_chk("R5 map byte0", 1, 0, 8'hFD);
    rd_chk("R5 sts bit2", 0, 0, 8'h04);
    rd_chk("R5 map byte2 kept", 1, 2, 8'h10);
    // unmapped event offsets
    wr(0, 5, 8'h00);
    rd_chk("R10 unmapped read", 0, 5, 8'hFF);
    rd_chk("R10 sts kept", 0, 0, 8'h04);
    rd_chk("R10 en kept", 0, 2, 8'h06);
    // bitmap writes ignored
    wr(1, 0, 8'h00);
    rd_chk("R12 map byte0", 1, 0, 8'hFD);
    // slot events
    slot_ev(5'd7, 1'b1);
    chk("R6 up", slot_up, 32'h0000_0080);
    chk("R6 down", slot_down, 32'd0);
    rd_chk("R6 sts", 0, 0, 8'h06);
    slot_ev(5'd3, 1'b0);
    chk("R7 up", slot_up, 32'd0);
    chk("R7 down", slot_down, 32'h0000_0008);
    slot_ev(5'd31, 1'b1);
    chk("R6 top slot", slot_up, 32'h8000_0000);
    // enable masks the event
    wr(0, 2, 8'h00);
    chk("R9 masked", {31'd0, gpe_event}, 32'd0);
    wr(0, 2, 8'h02);
    chk("R9 slot bit", {31'd0, gpe_event}, 32'd1);
    // set wins over clear
    wr(0, 0, 8'hFF);
    rd_chk("R2 all clear", 0, 0, 8'h00);
    @(negedge clk);
    acc_win = 0; acc_addr = 0; acc_wdata = 8'h06; acc_wr = 1'b1;
    cpu_evt_valid = 1'b1; cpu_evt_idx = 8'd200; cpu_evt_insert = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0; cpu_evt_valid = 1'b0;
    rd_chk("R11 set wins", 0, 0, 8'h04);
    rd_chk("R4 high index", 1, 25, 8'h01);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule